// File: doc/BRIEF.md
# Strobed PCM Timeslot Serial Port

This block is the digital serial port of a telephony voice codec. In each 8 kHz frame it moves one 8-bit companded sample in each direction. The frame is marked by an active-high strobe, and the same strobe window serves both transmit and receive. Outgoing bits are launched on rising bit-clock edges. Incoming bits are captured on falling bit-clock edges. The pad-level output enable is asserted only inside the window.

The port runs in a single fast core clock domain. It synchronises the bit clock, the strobe and the serial input, and finds their edges by comparing successive samples. The transmit byte is taken from a parallel input when the strobe rises. The received byte appears on a parallel output together with a one-cycle valid pulse.

Either mute input replaces the affected byte with the negative-zero code of the companding law chosen by the law-select input.

Top module: `pcm_slot_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state is cleared: `sdout_oe` is 0, `rx_valid` is 0 and `rx_sample` is 8'h00.
- R2: `sdout_oe` stays 0 from the strobe rise until the first rising bit-clock edge inside the window. It then stays 1 until the strobe falls, and returns to 0 after the strobe falls.
- R3: The transmit byte is captured from `tx_sample` when the strobe rises. Changes to `tx_sample` later in the window have no effect.
- R4: The captured transmit byte is shifted out MSB first. Each rising bit-clock edge in the window presents the next bit on `sdout`.
- R5: `sdin` is sampled on each of the first eight falling bit-clock edges in the window, MSB first. After the eighth sample, `rx_sample` shows the byte and `rx_valid` is high for exactly one core-clock cycle.
- R6: If `tx_mute` is 1 when the strobe rises, the transmitted byte is the negative-zero code in place of `tx_sample`.
- R7: If `rx_mute` is 1 when the eighth receive bit is taken, `rx_sample` presents the negative-zero code in place of the received bits.
- R8: The negative-zero code is 8'h55 when `law_sel` is 1 (A-law) and 8'h7F when `law_sel` is 0 (µ-law).
- R9: If the strobe falls before eight falling edges have been seen, the partial receive byte is discarded and no `rx_valid` pulse occurs. The following full frame is received correctly.
- R10: Bit-clock edges beyond the eighth inside one window are ignored. `sdout` holds the last bit, and no further bits or valid pulses are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low power-up reset, sampled synchronously |
| bit_clk | input | 1 | Serial bit clock |
| strobe | input | 1 | Active-high timeslot strobe, 8 kHz repetition |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Output enable for the tri-state pad driver of `sdout` |
| tx_sample | input | 8 | Parallel sample to transmit |
| rx_sample | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle pulse when `rx_sample` is updated |
| tx_mute | input | 1 | Replace the transmit byte with negative zero |
| rx_mute | input | 1 | Replace the received byte with negative zero |
| law_sel | input | 1 | Companding law: 1 = A-law, 0 = µ-law |

## Verification
Two cases are hard to reach from the ports: a strobe window that closes part-way through a byte, and a window that carries more than eight bit-clock cycles. The bench stretches or cuts the strobe around a chosen number of bit-clock pulses to create both. It drives different `sdin` values on the surplus pulses, so that any bit wrongly taken after the eighth would change the received byte. The scoreboard queues one expected byte only for each complete frame. A valid pulse that arrives with the queue empty is therefore a failure, and this catches a partial byte that leaks through.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SAMPLE_W    = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sig_edges_t;

    localparam logic [SAMPLE_W-1:0] NZ_MU = 8'h7F;
    localparam logic [SAMPLE_W-1:0] NZ_A  = 8'h55;

    function automatic logic [SAMPLE_W-1:0] neg_zero(input law_e law);
        return (law == LAW_A) ? NZ_A : NZ_MU;
    endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
    import pcm_port_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       async_in,
    output sig_edges_t edges
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    always_comb begin
        edges.level = chain_q[STAGES-1];
        edges.rise  = chain_q[STAGES-1] & ~prev_q;
        edges.fall  = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
    import pcm_port_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         win_i,
    input  logic         bclk_rise_i,
    input  logic [W-1:0] par_i,
    input  logic         mute_i,
    input  law_e         law_i,
    output logic         ser_o,
    output logic         oe_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     shreg_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            oe_o    <= 1'b0;
            ser_o   <= 1'b0;
        end else if (load_i) begin
            shreg_q <= mute_i ? neg_zero(law_i) : par_i;
            cnt_q   <= '0;
            oe_o    <= 1'b0;
        end else if (!win_i) begin
            cnt_q <= '0;
            oe_o  <= 1'b0;
        end else if (bclk_rise_i && (cnt_q < CNT_W'(W))) begin
            ser_o   <= shreg_q[W-1];
            shreg_q <= {shreg_q[W-2:0], 1'b0};
            cnt_q   <= cnt_q + 1'b1;
            oe_o    <= 1'b1;
        end
    end

    p_mute_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mute_i) |=> (shreg_q == neg_zero($past(law_i))));

    p_bit_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(W));

    p_oe_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> $past(win_i));
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer
    import pcm_port_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         win_i,
    input  logic         bclk_fall_i,
    input  logic         ser_i,
    input  logic         mute_i,
    input  law_e         law_i,
    output logic [W-1:0] par_o,
    output logic         valid_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     shreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     next_word;

    assign next_word = {shreg_q[W-2:0], ser_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            par_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start_i) begin
                shreg_q <= '0;
                cnt_q   <= '0;
            end else if (!win_i) begin
                cnt_q <= '0;
            end else if (bclk_fall_i && (cnt_q < CNT_W'(W))) begin
                shreg_q <= next_word;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(W - 1)) begin
                    par_o   <= mute_i ? neg_zero(law_i) : next_word;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnt_q == CNT_W'(W)));

    p_no_valid_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i |=> !valid_o);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk,
    input  logic       strobe,
    input  logic       sdin,
    output logic       sdout,
    output logic       sdout_oe,
    input  logic [7:0] tx_sample,
    output logic [7:0] rx_sample,
    output logic       rx_valid,
    input  logic       tx_mute,
    input  logic       rx_mute,
    input  logic       law_sel
);
    sig_edges_t bclk_e, stb_e, din_e;
    law_e       law;

    assign law = law_e'(law_sel);

    pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (
        .clk(clk), .rst_n(rst_n), .async_in(bit_clk), .edges(bclk_e));
    pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .async_in(strobe), .edges(stb_e));
    pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .async_in(sdin), .edges(din_e));

    pcm_tx_serializer #(.W(SAMPLE_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (stb_e.rise),
        .win_i      (stb_e.level),
        .bclk_rise_i(bclk_e.rise),
        .par_i      (tx_sample),
        .mute_i     (tx_mute),
        .law_i      (law),
        .ser_o      (sdout),
        .oe_o       (sdout_oe)
    );

    pcm_rx_deserializer #(.W(SAMPLE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (stb_e.rise),
        .win_i      (stb_e.level),
        .bclk_fall_i(bclk_e.fall),
        .ser_i      (din_e.level),
        .mute_i     (rx_mute),
        .law_i      (law),
        .par_o      (rx_sample),
        .valid_o    (rx_valid)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!sdout_oe && !rx_valid && rx_sample == 8'h00));
endmodule

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_clk = 1'b0;
    logic       strobe = 1'b0;
    logic       sdin = 1'b0;
    logic       sdout, sdout_oe;
    logic [7:0] tx_sample = 8'h00;
    logic [7:0] rx_sample;
    logic       rx_valid;
    logic       tx_mute = 1'b0;
    logic       rx_mute = 1'b0;
    logic       law_sel = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    pcm_slot_port dut (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .strobe(strobe),
        .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe),
        .tx_sample(tx_sample), .rx_sample(rx_sample), .rx_valid(rx_valid),
        .tx_mute(tx_mute), .rx_mute(rx_mute), .law_sel(law_sel));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] nz(input logic law);
        return law ? 8'h55 : 8'h7F;
    endfunction

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Monitor: pops expected received bytes as valid pulses appear.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rx_valid", int'(rx_sample), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rx_sample == e, t, int'(rx_sample), int'(e));
            end
        end
    end

    // One strobe window with npulse bit-clock pulses.
    task automatic frame(input logic [7:0] txb, input logic [7:0] rxb,
                         input logic txm, input logic rxm, input logic law,
                         input int npulse, input string rtag);
        automatic logic [7:0] etx = txm ? nz(law) : txb;
        tx_sample = txb;
        tx_mute   = txm;
        rx_mute   = rxm;
        law_sel   = law;
        if (npulse >= 8) begin
            exp_q.push_back(rxm ? nz(law) : rxb);
            tag_q.push_back(rtag);
        end
        strobe = 1'b1;
        wait_n(HALF);
        check(sdout_oe == 1'b0, "R2 oe before first edge", int'(sdout_oe), 0);
        for (int i = 0; i < npulse; i++) begin
            bit_clk = 1'b1;
            sdin = (i < 8) ? rxb[7-i] : ~rxb[0];
            wait_n(HALF);
            if (i == 0) tx_sample = ~txb;  // R3: late change must not matter
            check(sdout_oe == 1'b1, "R2 oe in window", int'(sdout_oe), 1);
            if (i < 8)
                check(sdout == etx[7-i], txm ? "R6/R8 tx mute bit" : "R4 tx bit",
                      int'(sdout), int'(etx[7-i]));
            else
                check(sdout == etx[0], "R10 tx holds last bit", int'(sdout), int'(etx[0]));
            bit_clk = 1'b0;
            wait_n(HALF);
        end
        strobe = 1'b0;
        wait_n(HALF);
        check(sdout_oe == 1'b0, "R2 oe after strobe", int'(sdout_oe), 0);
        wait_n(HALF);
    endtask

    initial begin
        wait_n(5);
        check(sdout_oe == 1'b0, "R1 reset oe", int'(sdout_oe), 0);
        check(rx_valid == 1'b0, "R1 reset valid", int'(rx_valid), 0);
        check(rx_sample == 8'h00, "R1 reset rx_sample", int'(rx_sample), 0);
        rst_n = 1'b1;
        wait_n(4);

        frame(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 8, "R5 rx byte");
        frame(8'h81, 8'hE7, 1'b0, 1'b0, 1'b1, 8, "R5 rx byte A-law");
        frame(8'h12, 8'h9A, 1'b1, 1'b0, 1'b0, 8, "R5 rx byte tx muted");
        frame(8'h12, 8'h9A, 1'b1, 1'b0, 1'b1, 8, "R5 rx byte tx muted A");
        frame(8'hF0, 8'h0F, 1'b0, 1'b1, 1'b0, 8, "R7/R8 rx mute mu-law");
        frame(8'hF0, 8'h0F, 1'b0, 1'b1, 1'b1, 8, "R7/R8 rx mute A-law");
        frame(8'hC3, 8'h5A, 1'b0, 1'b0, 1'b0, 3, "R9 short");
        frame(8'h66, 8'hB2, 1'b0, 1'b0, 1'b0, 8, "R9 frame after short");
        frame(8'h01, 8'hD4, 1'b0, 1'b0, 1'b0, 11, "R10 extra edges");
        frame(8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 8, "R5 rx all ones");

        wait_n(10);
        check(exp_q.size() == 0, "R5 missing rx_valid", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule